// File: doc/BRIEF.md
# Microcoded Memory Pattern Sequencer

This block executes one memory access as a short program held in a small pattern RAM. A start request supplies an entry address. From the next cycle on, the sequencer reads one pattern word per clock and drives its strobe field onto the strobe outputs. The strobe bits carry no meaning inside the block. The program ends after the word flagged as last has run, and a one-cycle done flag then marks the end of the access.

Some devices cannot promise a fixed access time, so a pattern word may ask the sequencer to wait for them. The device's wait line is asynchronous and passes through a two-stage synchroniser. The sequencer freezes on a word only when three conditions hold together: the word's wait-enable bit is set, the mode enable input allows waiting, and the synchronised wait is high. While frozen, it holds its position and its strobes. Once the wait drops, it moves on to the following word. Pattern words are loaded through a write port, and this port works only while the sequencer is idle.

Top module: `mem_pattern_seq`

## Requirements
- R1: After reset, `strobe_o` is 0 and `done_o` is 0, and the sequencer is idle. While idle, both outputs stay 0.
- R2: A start accepted in idle loads `start_addr_i` as the word position. The stored word's bits 7:0 appear on `strobe_o` in the cycle after the start edge. Each later cycle advances the position by one, and the position wraps from 63 to 0.
- R3: Bit 9 of a pattern word is its last flag. After the last word has been shown for its cycle, `done_o` is 1 for exactly one cycle with `strobe_o` at 0. The sequencer is then idle.
- R4: `start_i` is ignored while an access is in progress, and this includes the done cycle.
- R5: A pattern word is 10 bits: bit 9 is the last flag, bit 8 is the wait enable and bits 7:0 are the strobes. A write is stored only when it arrives in an idle cycle. A write during an access has no effect.
- R6: `ext_wait_i` goes through two flip-flop stages. The freeze decision at a clock edge uses the wait level that was sampled two edges earlier.
- R7: At an edge where the current word has bit 8 set, `wait_mode_en_i` is 1 and the synchronised wait is 1, the sequencer freezes. It keeps the same word and the same strobes.
- R8: A frozen sequencer resumes when the synchronised wait (gated by the mode enable) is 0. It continues at the next word, or it goes to the done cycle if the frozen word was last.
- R9: With `wait_mode_en_i` at 0, the wait input has no effect.
- R10: A word whose bit 8 is 0 never freezes, whatever the wait input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access start request |
| start_addr_i | input | 6 | Entry word address |
| wr_en_i | input | 1 | Pattern write enable |
| wr_addr_i | input | 6 | Pattern write address |
| wr_data_i | input | 10 | Pattern word {last, wait enable, strobes} |
| ext_wait_i | input | 1 | Asynchronous wait from the device, active high |
| wait_mode_en_i | input | 1 | Allows the wait feature |
| strobe_o | output | 8 | Strobe field of the current word |
| done_o | output | 1 | One-cycle end-of-access flag |

## Verification
Outputs change only at rising edges and depend only on registered state and stored words. The bench therefore compares them every cycle at the falling edge against a bench-side model, and it drives inputs at that same falling edge. A start shows its first word one edge later. Done follows one edge after the last word. A wait level first affects the freeze decision at the third rising edge after it is driven (two synchroniser edges, then the decision), and release follows the same latency. The model reproduces these latencies from the requirements, so an access that runs one cycle early or late fails the compare with the tag of the active scenario.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FRZ  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mps_wait_sync.sv
module mps_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    mem_q[e] <= '0;
        else if (we_i && (waddr_i == ADDR_W'(e)))       mem_q[e] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mps_seq_ctrl.sv
module mps_seq_ctrl
  import mps_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned STROBE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic [STROBE_W+1:0]   word_i,
  input  logic                  wait_s_i,
  input  logic                  wait_mode_en_i,
  output logic [ADDR_W-1:0]     pos_o,
  output seq_state_e            state_o,
  output logic                  idle_o,
  output logic [STROBE_W-1:0]   strobe_o,
  output logic                  done_o
);
  localparam int unsigned WAIT_BIT = STROBE_W;
  localparam int unsigned LAST_BIT = STROBE_W + 1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pos_q, pos_d;
  logic              wait_live;
  logic              hold_req;
  logic              is_last;

  assign wait_live = wait_mode_en_i & wait_s_i;
  assign hold_req  = word_i[WAIT_BIT] & wait_live;
  assign is_last   = word_i[LAST_BIT];

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          pos_d   = start_addr_i;
        end
      end
      ST_RUN: begin
        if (hold_req)     state_d = ST_FRZ;
        else if (is_last) state_d = ST_DONE;
        else              pos_d   = pos_q + 1'b1;
      end
      ST_FRZ: begin
        if (!wait_live) begin
          if (is_last) state_d = ST_DONE;
          else begin
            state_d = ST_RUN;
            pos_d   = pos_q + 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  assign pos_o    = pos_q;
  assign state_o  = state_q;
  assign idle_o   = (state_q == ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign strobe_o = ((state_q == ST_RUN) || (state_q == ST_FRZ)) ? word_i[STROBE_W-1:0]
                                                                 : '0;
endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
  import mps_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned STROBE_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [STROBE_W+1:0]   wr_data_i,
  input  logic                  ext_wait_i,
  input  logic                  wait_mode_en_i,
  output logic [STROBE_W-1:0]   strobe_o,
  output logic                  done_o
);
  localparam int unsigned WORD_W = STROBE_W + 2;

  logic              wait_sync;
  logic              seq_idle;
  logic [ADDR_W-1:0] seq_pos;
  seq_state_e        seq_state;
  logic [WORD_W-1:0] cur_word;

  mps_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_wait_i),
    .sync_o  (wait_sync)
  );

  mps_pattern_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i & seq_idle),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (seq_pos),
    .rdata_o (cur_word)
  );

  mps_seq_ctrl #(.ADDR_W(ADDR_W), .STROBE_W(STROBE_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .start_addr_i   (start_addr_i),
    .word_i         (cur_word),
    .wait_s_i       (wait_sync),
    .wait_mode_en_i (wait_mode_en_i),
    .pos_o          (seq_pos),
    .state_o        (seq_state),
    .idle_o         (seq_idle),
    .strobe_o       (strobe_o),
    .done_o         (done_o)
  );
endmodule

// File: rtl/mps_checker.sv
module mps_checker
  import mps_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned STROBE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wait_mode_en_i,
  input logic                done_o,
  input logic [STROBE_W-1:0] strobe_o,
  input seq_state_e          state,
  input logic [ADDR_W-1:0]   pos,
  input logic [STROBE_W+1:0] word,
  input logic                wait_sync
);
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN) && !word[STROBE_W] && !word[STROBE_W+1]
      |=> (state == ST_RUN) && (pos == ADDR_W'($past(pos) + 1'b1)));

  a_r7_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FRZ) && wait_sync && wait_mode_en_i
      |=> (state == ST_FRZ) && $stable(pos) && $stable(strobe_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FRZ) && !wait_sync |=> (state != ST_FRZ));

  a_r9_mode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_mode_en_i |=> (state != ST_FRZ));

  a_r10_no_wait_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN) && !word[STROBE_W] |=> (state != ST_FRZ));
endmodule

bind mem_pattern_seq mps_checker #(.ADDR_W(ADDR_W), .STROBE_W(STROBE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wait_mode_en_i (wait_mode_en_i),
  .done_o         (done_o),
  .strobe_o       (strobe_o),
  .state          (seq_state),
  .pos            (seq_pos),
  .word           (cur_word),
  .wait_sync      (wait_sync)
);

// File: tb/tb_mem_pattern_seq.sv
module tb_mem_pattern_seq;
  localparam int AW = 6;
  localparam int SW = 8;
  localparam int WW = SW + 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic          ext_wait = 1'b0;
  logic          mode_en = 1'b0;
  logic [SW-1:0] strobe;
  logic          done;

  always #2 clk = ~clk;

  mem_pattern_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ext_wait_i(ext_wait), .wait_mode_en_i(mode_en),
    .strobe_o(strobe), .done_o(done)
  );

  // reference model built from the requirements: 0 idle, 1 run, 2 frozen, 3 done
  logic [WW-1:0] m_mem [DEPTH];
  int            m_st;
  logic [AW-1:0] m_pos;
  logic          m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_pos <= '0; m_s1 <= 1'b0; m_s2 <= 1'b0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] <= '0;
    end else begin
      m_s1 <= ext_wait;
      m_s2 <= m_s1;
      if (m_st == 0 && wr_en) m_mem[wr_addr] <= wr_data;  // R5
      case (m_st)
        0: if (start) begin m_st <= 1; m_pos <= start_addr; end
        1: if (m_mem[m_pos][8] && mode_en && m_s2) m_st <= 2;   // R6 R7
           else if (m_mem[m_pos][9]) m_st <= 3;
           else m_pos <= m_pos + 1'b1;
        2: if (!(mode_en && m_s2)) begin                         // R8
             if (m_mem[m_pos][9]) m_st <= 3;
             else begin m_st <= 1; m_pos <= m_pos + 1'b1; end
           end
        default: m_st <= 0;
      endcase
    end
  end

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    running = 1'b0;
  int    cyc = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(tag, {24'd0, strobe}, (m_st == 1 || m_st == 2) ? {24'd0, m_mem[m_pos][7:0]} : 32'd0);
      chk(tag, {31'd0, done}, {31'd0, (m_st == 3)});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [AW-1:0] a, logic [WW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick(logic [AW-1:0] a);
    @(negedge clk);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (m_st == 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    running = 1'b1;
    tag = "R1";
    chk("R1", {24'd0, strobe}, 32'd0);
    chk("R1", {31'd0, done}, 32'd0);
    step(3);

    // R2 R3: straight pattern 10..14, last at 14
    tag = "R2";
    for (int i = 0; i < 4; i++) write_word(AW'(10 + i), {2'b00, 8'(8'h11 * (i + 1))});
    write_word(6'd14, {2'b10, 8'hA5});
    kick(6'd10);
    chk("R2", {24'd0, strobe}, 32'h11);
    tag = "R3";
    wait_idle();
    step(1);

    // R4: start while busy ignored
    tag = "R4";
    kick(6'd10);
    step(1);
    start = 1'b1; start_addr = 6'd12;
    step(1);
    start = 1'b0;
    wait_idle();

    // R5: write during access is dropped
    tag = "R5";
    kick(6'd10);
    wr_en = 1'b1; wr_addr = 6'd13; wr_data = {2'b00, 8'hEE};
    step(1);
    wr_en = 1'b0;
    wait_idle();
    kick(6'd10);
    wait_idle();

    // R2: wrap 62, 63, 0
    tag = "R2";
    write_word(6'd62, {2'b00, 8'h62});
    write_word(6'd63, {2'b00, 8'h63});
    write_word(6'd0, {2'b10, 8'h0F});
    kick(6'd62);
    wait_idle();

    // R6 R7 R8: word 11 waits
    write_word(6'd11, {2'b01, 8'h3C});
    mode_en = 1'b1;
    tag = "R7";
    ext_wait = 1'b1;
    kick(6'd10);
    step(6);
    tag = "R8";
    ext_wait = 1'b0;
    wait_idle();

    // R6: late wait pulse, exact latency exercised
    tag = "R6";
    kick(6'd10);
    ext_wait = 1'b1;
    step(5);
    ext_wait = 1'b0;
    wait_idle();

    // R8: freeze on a last word
    tag = "R8";
    write_word(6'd20, {2'b11, 8'h77});
    ext_wait = 1'b1;
    kick(6'd20);
    step(4);
    ext_wait = 1'b0;
    wait_idle();

    // R9: mode off, wait ignored
    tag = "R9";
    mode_en = 1'b0;
    ext_wait = 1'b1;
    kick(6'd10);
    wait_idle();
    ext_wait = 1'b0;

    // R10: no wait bit, wait ignored
    tag = "R10";
    mode_en = 1'b1;
    ext_wait = 1'b1;
    kick(6'd12);
    wait_idle();
    ext_wait = 1'b0;
    step(3);

    // random mix
    tag = "R7";
    void'($urandom(32'h5eed1234));
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      wr_en    = ($urandom % 3) == 0;
      wr_addr  = AW'($urandom % 16);
      wr_data  = WW'($urandom);
      start    = ($urandom % 4) == 0;
      start_addr = AW'($urandom % 16);
      ext_wait = ($urandom % 3) == 0;
      mode_en  = ($urandom % 5) != 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        wr_en = ($urandom % 4) == 0;
        wr_addr = AW'($urandom % 16);
        wr_data = WW'($urandom);
        start = ($urandom % 6) == 0;
        if (($urandom % 4) == 0) ext_wait = ~ext_wait;
      end
      wr_en = 1'b0; start = 1'b0; ext_wait = 1'b0;
      wait_idle();
    end

    step(2);
    running = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule